// File: doc/BRIEF.md
# Reference Clock Loss Detector

This block tells software whether the reference clock that feeds a clock multiplier is still running. It is clocked by the multiplied (VCO-derived) clock, which keeps oscillating when the reference stops, so the detector never waits on a reference edge to make progress.

A check starts with a one-cycle start strobe, which stands for software writing a one to the status bit. On that strobe the status bit is forced to 1 ("reference absent"). The block captures the 4-bit multiplier value and opens a window of four times that many clock cycles. The reference is brought into the counting domain through a synchronizer and its rising edges are detected. The first rising edge seen inside the window clears the status bit. When the window expires the block pulses a done output for one cycle. The status bit then keeps its verdict until the next start.

Top module: `refloss_det`

## Requirements
- R1: After a synchronous reset, `loss_o` and `done_o` are both 0 and no window is open.
- R2: In the cycle after a start strobe is sampled, `loss_o` reads 1, whatever it held before.
- R3: `done_o` goes high exactly 4×N clock cycles after the edge that samples the start strobe, where N is `mult_i` captured with the start; an N of 0 gives the same window as an N of 1.
- R4: `done_o` is high for exactly one cycle per completed window.
- R5: If the reference shows no rising edge during the window, `loss_o` is still 1 when `done_o` is high.
- R6: If the reference keeps toggling during the window, `loss_o` is 0 when `done_o` is high.
- R7: Once the window has closed, `loss_o` keeps its value until the next start strobe, and reference activity has no effect on it.
- R8: A start strobe while a window is open restarts the window from its full length and sets `loss_o` to 1 again. The earlier window produces no `done_o`.
- R9: `mult_i` is sampled only with the start strobe. Changing it while a window is open does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock (VCO-derived) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe: write of one to the status bit |
| mult_i | input | 4 | Programmed multiplier N (1 to 15; 0 treated as 1) |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| loss_o | output | 1 | Status: 1 = reference not seen, 0 = reference seen |
| done_o | output | 1 | One-cycle pulse when the window expires |

## Verification
The bench sweeps every multiplier value from 0 to 15. For each one it runs a window with the reference stopped and a window with it running, and compares the done cycle with 4×N counted from the start sample. An off-by-one counter, or a window that ignores the zero-multiplier floor, shows up as done arriving a cycle early or late. A window that uses the live multiplier rather than the captured one shows up when the multiplier is moved mid-window. A restart that fails to reload the counter gives a done pulse too early. A status bit that keeps listening after the window shows up when the reference starts again after a loss verdict.

// File: rtl/refloss_pkg.sv
package refloss_pkg;
  localparam int unsigned DEF_MULT_W  = 4;
  localparam int unsigned DEF_PER_MUL = 4;
  localparam int unsigned DEF_SYNC    = 2;

  // window length in counting-clock cycles for a multiplier value
  function automatic int unsigned win_cycles(input int unsigned n,
                                             input int unsigned per);
    int unsigned eff;
    eff = (n == 0) ? 1 : n;
    return eff * per;
  endfunction
endpackage

// File: rtl/refloss_sync.sv
module refloss_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // R6: a synchronized rise cannot repeat on back-to-back cycles
  a_r6_rise_spacing: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/refloss_window.sv
module refloss_window
  import refloss_pkg::*;
#(
  parameter int unsigned MULT_W  = DEF_MULT_W,
  parameter int unsigned PER_MUL = DEF_PER_MUL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              active_o,
  output logic              done_o
);
  localparam int unsigned MAX_WIN = ((1 << MULT_W) - 1) * PER_MUL;
  localparam int unsigned CNT_W   = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= CNT_W'(win_cycles(int'(mult_i), PER_MUL) - 1);
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;

  // R3: done only follows an open window
  a_r3_done_after_window: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(active_q));
  // R8: a start always leaves a window open
  a_r8_start_opens: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (active_q && !done_q));
endmodule

// File: rtl/refloss_det.sv
module refloss_det
  import refloss_pkg::*;
#(
  parameter int unsigned MULT_W      = DEF_MULT_W,
  parameter int unsigned PER_MUL     = DEF_PER_MUL,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              ref_clk_i,
  output logic              loss_o,
  output logic              done_o
);
  logic ref_rise;
  logic win_active;
  logic win_done;
  logic loss_q;

  refloss_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i (ref_clk_i),
    .rise_o  (ref_rise)
  );

  refloss_window #(.MULT_W(MULT_W), .PER_MUL(PER_MUL)) win_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .mult_i   (mult_i),
    .active_o (win_active),
    .done_o   (win_done)
  );

  always_ff @(posedge clk) begin
    if (rst)                         loss_q <= 1'b0;
    else if (start_i)                loss_q <= 1'b1;
    else if (win_active && ref_rise) loss_q <= 1'b0;
  end

  assign loss_o = loss_q;
  assign done_o = win_done;

  // R2: start forces the status bit high
  a_r2_start_sets: assert property (@(posedge clk) disable iff (rst)
    start_i |=> loss_o);
  // R4: done lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7: with the window closed the verdict holds
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!win_active && !start_i) |=> $stable(loss_o));
  // R6: an edge inside the window clears the status bit
  a_r6_edge_clears: assert property (@(posedge clk) disable iff (rst)
    (win_active && ref_rise && !start_i) |=> !loss_o);
endmodule

// File: tb/refloss_det_tb_top.sv
module refloss_det_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [3:0] mult_i = 4'd6;
  logic       ref_clk_i = 1'b0;
  logic       ref_en = 1'b0;
  logic       loss_o, done_o;
  int         checks = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;
  initial forever begin
    #4;
    ref_clk_i = ref_en ? ~ref_clk_i : 1'b0;
  end

  refloss_det dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mult_i(mult_i),
    .ref_clk_i(ref_clk_i), .loss_o(loss_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input logic en);
    ref_en = en;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [3:0] n);
    mult_i  = n;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // waits for done; returns negedges counted since the start negedge
  task automatic wait_done(output int k);
    k = 1;
    while (!done_o && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  function automatic int exp_k(input int n);
    return 4 * ((n == 0) ? 1 : n) + 1;
  endfunction

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 loss after reset", loss_o, 0);
    chk("R1 done after reset", done_o, 0);

    for (int n = 0; n < 16; n++) begin
      // stopped reference
      settle(1'b0);
      pulse_start(4'(n));
      chk("R2 loss set after start", loss_o, 1);
      wait_done(k);
      chk("R3 window length (ref stopped)", k, exp_k(n));
      chk("R5 loss kept with no edge", loss_o, 1);
      @(negedge clk);
      chk("R4 done one cycle", done_o, 0);
      // running reference
      settle(1'b1);
      pulse_start(4'(n));
      wait_done(k);
      chk("R3 window length (ref running)", k, exp_k(n));
      chk("R6 loss cleared by edges", loss_o, 0);
    end

    // R7: activity after a closed window is ignored
    settle(1'b0);
    pulse_start(4'd2);
    wait_done(k);
    ref_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 loss held after window", loss_o, 1);
    chk("R7 no stray done", done_o, 0);
    // R7: stopping the reference after a clean verdict is ignored
    pulse_start(4'd1);
    wait_done(k);
    ref_en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 clear verdict held", loss_o, 0);

    // R8: restart mid-window
    settle(1'b0);
    pulse_start(4'd3);
    begin
      int seen = 0;
      repeat (5) begin
        if (done_o) seen++;
        @(negedge clk);
      end
      chk("R8 no done before restart", seen, 0);
    end
    pulse_start(4'd3);
    wait_done(k);
    chk("R8 restarted window length", k, exp_k(3));
    // R8: restart after edges re-arms loss
    settle(1'b1);
    pulse_start(4'd4);
    repeat (8) @(negedge clk);
    ref_en = 1'b0;
    repeat (3) @(negedge clk);
    pulse_start(4'd4);
    chk("R8 loss re-armed by restart", loss_o, 1);
    wait_done(k);
    chk("R8 restart window with ref stopped", k, exp_k(4));
    chk("R8 loss verdict after restart", loss_o, 1);

    // R9: multiplier moved during window
    settle(1'b0);
    pulse_start(4'd2);
    mult_i = 4'd15;
    wait_done(k);
    chk("R9 captured multiplier", k, exp_k(2));
    mult_i = 4'd1;
    pulse_start(4'd15);
    mult_i = 4'd1;
    wait_done(k);
    chk("R9 captured max multiplier", k, exp_k(15));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #900000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule